// File: doc/BRIEF.md
# Branch Target Buffer with Next-Fetch Select

This block sits in the fetch stage. It keeps a small direct-mapped table of the taken-target addresses of branches that have already resolved. Each cycle it looks up the current fetch address. A hit says that the fetched instruction is a branch and supplies its target. In the same cycle the block combines that result with a direction bit from an external predictor and produces the address to fetch next.

Entries are written only from the resolve side of the pipeline. When a branch resolves, its address, its actual target and an is-branch flag are presented on the update port. Non-branch updates leave the table alone. The block contains no direction predictor, no decoder and no flush logic. It only uses the taken bit and supplies the target.

Top module: `btb_fetch_target`

## Requirements
- R1: When reset is asserted, and for as long as it is held, every lookup misses. After reset is released, lookups still miss until a branch update has written the entry.
- R2: A PC is split as follows: bits [1:0] are ignored, bits [7:2] select one of 64 entries, and bits [31:8] form the tag. A lookup hits only when the selected entry is valid and its stored tag equals the fetch tag.
- R3: An update with `upd_valid`=1 and `upd_is_branch`=1 writes the valid bit, the tag and the target in one clock edge. From the next cycle a lookup of that PC hits and returns that target. Entries at other indices are unchanged.
- R4: An update with `upd_is_branch`=0 changes no entry.
- R5: On a miss, `pred_target` is zero and `next_pc` is `fetch_pc`+4.
- R6: On a hit with `pred_taken`=1, `next_pc` equals `pred_target`.
- R7: On a hit with `pred_taken`=0, `next_pc` is `fetch_pc`+4. `pred_target` still shows the stored target.
- R8: When a lookup and an update address the same index in the same cycle, the lookup sees the contents from before the update.
- R9: A branch update whose tag differs from the resident tag at its index replaces that entry. The previous branch then misses.
- R10: The two low bits of a target are not stored and read back as zero.
- R11: The sequential address wraps modulo 2^32, so `fetch_pc`=0xFFFFFFFC gives `next_pc`=0x00000000 whenever the sequential path is chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_pc | input | 32 | Address being fetched this cycle |
| pred_taken | input | 1 | Direction guess from the external predictor, 1 = taken |
| upd_valid | input | 1 | An update is presented this cycle |
| upd_is_branch | input | 1 | The resolved instruction was a branch |
| upd_pc | input | 32 | Address of the resolved instruction |
| upd_target | input | 32 | Actual target of the resolved branch |
| hit | output | 1 | The fetched instruction is a known branch |
| pred_target | output | 32 | Cached target on a hit, zero on a miss |
| next_pc | output | 32 | Selected next fetch address |

## Verification
A corrupted valid bit, tag or target is visible at the ports in the very cycle the affected index is looked up. It shows as a wrong `hit`, a wrong `pred_target`, or a `next_pc` that takes the wrong path. A write that is missing, misdirected or spurious shows one cycle after the update edge, when the written address or one of its index neighbours is looked up. The bench therefore reads back written entries, aliases of written entries and untouched entries right after each update. It also samples in the same cycle as each update, to catch a read that is forwarded too early.

// File: rtl/btb_pkg.sv
package btb_pkg;
  localparam int ADDR_W_DEF     = 32;
  localparam int ENTRIES_DEF    = 64;
  localparam int INST_BYTES_DEF = 4;

  // select between the cached target and the sequential address
  typedef enum logic {
    SEL_SEQ    = 1'b0,
    SEL_TARGET = 1'b1
  } next_sel_e;
endpackage

// File: rtl/btb_rst_sync.sv
module btb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_ok = sync_q[1];
endmodule

// File: rtl/btb_addr_split.sv
module btb_addr_split #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 2,
  parameter int IDX_W  = 6,
  parameter int TAG_W  = ADDR_W - OFF_W - IDX_W
) (
  input  logic [ADDR_W-1:0] pc,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag
);
  logic unused_offset;

  assign idx = pc[OFF_W +: IDX_W];
  assign tag = pc[ADDR_W-1 -: TAG_W];
  assign unused_offset = &{1'b0, pc[OFF_W-1:0]};
endmodule

// File: rtl/btb_store.sv
module btb_store #(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = 6,
  parameter int TAG_W   = 24,
  parameter int TGT_W   = 30
) (
  input  logic             clk,
  input  logic             rst_ok,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [TGT_W-1:0] wr_tgt,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [TGT_W-1:0] rd_tgt
);
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] valid_d;
  logic [ENTRIES-1:0] we;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [TGT_W-1:0]   tgt_q [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    always_comb begin
      we[i]      = wr_en && (wr_idx == IDX_W'(i));
      valid_d[i] = valid_q[i] | we[i];
    end

    always_ff @(posedge clk or negedge rst_ok) begin
      if (!rst_ok)    valid_q[i] <= 1'b0;
      else if (we[i]) valid_q[i] <= valid_d[i];
    end

    always_ff @(posedge clk) begin
      if (we[i]) begin
        tag_q[i] <= wr_tag;
        tgt_q[i] <= wr_tgt;
      end
    end
  end

  // reads see registered state, so a same-cycle write is not forwarded
  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_tgt   = tgt_q[rd_idx];
endmodule

// File: rtl/btb_next_sel.sv
module btb_next_sel #(
  parameter int ADDR_W     = 32,
  parameter int INST_BYTES = 4
) (
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic              hit,
  input  logic              pred_taken,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] next_pc
);
  import btb_pkg::*;
  next_sel_e sel;

  always_comb begin
    sel = (hit && pred_taken) ? SEL_TARGET : SEL_SEQ;
    unique case (sel)
      SEL_TARGET: next_pc = target;
      default:    next_pc = fetch_pc + ADDR_W'(INST_BYTES);
    endcase
  end
endmodule

// File: rtl/btb_fetch_target.sv
module btb_fetch_target #(
  parameter int ADDR_W     = btb_pkg::ADDR_W_DEF,
  parameter int ENTRIES    = btb_pkg::ENTRIES_DEF,
  parameter int INST_BYTES = btb_pkg::INST_BYTES_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic              pred_taken,
  input  logic              upd_valid,
  input  logic              upd_is_branch,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic [ADDR_W-1:0] upd_target,
  output logic              hit,
  output logic [ADDR_W-1:0] pred_target,
  output logic [ADDR_W-1:0] next_pc
);
  localparam int OFF_W = $clog2(INST_BYTES);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int TGT_W = ADDR_W - OFF_W;

  logic             rst_ok;
  logic [IDX_W-1:0] f_idx, u_idx;
  logic [TAG_W-1:0] f_tag, u_tag;
  logic             rd_valid;
  logic [TAG_W-1:0] rd_tag;
  logic [TGT_W-1:0] rd_tgt;
  logic             wr_en;
  logic             unused_tgt_low;

  btb_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ok(rst_ok));

  btb_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W))
    u_fsplit (.pc(fetch_pc), .idx(f_idx), .tag(f_tag));

  btb_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W))
    u_usplit (.pc(upd_pc), .idx(u_idx), .tag(u_tag));

  assign wr_en          = upd_valid && upd_is_branch;
  assign unused_tgt_low = &{1'b0, upd_target[OFF_W-1:0]};

  btb_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(TGT_W)) u_store (
    .clk(clk), .rst_ok(rst_ok),
    .wr_en(wr_en), .wr_idx(u_idx), .wr_tag(u_tag), .wr_tgt(upd_target[ADDR_W-1:OFF_W]),
    .rd_idx(f_idx), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_tgt(rd_tgt)
  );

  always_comb begin
    hit         = rd_valid && (rd_tag == f_tag);
    pred_target = hit ? {rd_tgt, {OFF_W{1'b0}}} : '0;
  end

  btb_next_sel #(.ADDR_W(ADDR_W), .INST_BYTES(INST_BYTES)) u_sel (
    .fetch_pc(fetch_pc), .hit(hit), .pred_taken(pred_taken),
    .target(pred_target), .next_pc(next_pc)
  );
endmodule

// File: rtl/btb_fetch_target_chk.sv
module btb_fetch_target_chk #(
  parameter int ADDR_W     = 32,
  parameter int INST_BYTES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_ok,
  input logic [ADDR_W-1:0] fetch_pc,
  input logic              pred_taken,
  input logic              upd_valid,
  input logic              upd_is_branch,
  input logic [ADDR_W-1:0] upd_pc,
  input logic [ADDR_W-1:0] upd_target,
  input logic              hit,
  input logic [ADDR_W-1:0] pred_target,
  input logic [ADDR_W-1:0] next_pc
);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(INST_BYTES - 1);

  AST_RESET_NO_HIT: assert property (@(posedge clk) !rst_n |-> !hit); // R1

  AST_WRITE_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_ok)
    ($past(rst_ok) && $past(upd_valid && upd_is_branch) && fetch_pc == $past(upd_pc))
    |-> (hit && pred_target == ($past(upd_target) & ~LOW_MASK))); // R3

  AST_NO_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rst_ok)
    ($past(rst_ok) && !$past(upd_valid && upd_is_branch) && $stable(fetch_pc))
    |-> ($stable(hit) && $stable(pred_target))); // R4

  AST_MISS_SEQ: assert property (@(posedge clk) disable iff (!rst_ok)
    !hit |-> (pred_target == '0 && next_pc == fetch_pc + ADDR_W'(INST_BYTES))); // R5

  AST_TAKEN_REDIRECT: assert property (@(posedge clk) disable iff (!rst_ok)
    (hit && pred_taken) |-> next_pc == pred_target); // R6

  AST_NOT_TAKEN_SEQ: assert property (@(posedge clk) disable iff (!rst_ok)
    (hit && !pred_taken) |-> next_pc == fetch_pc + ADDR_W'(INST_BYTES)); // R7

  AST_TARGET_ALIGNED: assert property (@(posedge clk) disable iff (!rst_ok)
    (pred_target & LOW_MASK) == '0); // R10
endmodule

bind btb_fetch_target btb_fetch_target_chk #(.ADDR_W(ADDR_W), .INST_BYTES(INST_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_ok(rst_ok), .fetch_pc(fetch_pc), .pred_taken(pred_taken),
  .upd_valid(upd_valid), .upd_is_branch(upd_is_branch), .upd_pc(upd_pc),
  .upd_target(upd_target), .hit(hit), .pred_target(pred_target), .next_pc(next_pc)
);

// File: tb/btb_fetch_target_test.sv
module btb_fetch_target_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] fetch_pc, upd_pc, upd_target;
  logic        pred_taken, upd_valid, upd_is_branch;
  logic        hit;
  logic [31:0] pred_target, next_pc;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  btb_fetch_target uut (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_taken(pred_taken),
    .upd_valid(upd_valid), .upd_is_branch(upd_is_branch), .upd_pc(upd_pc),
    .upd_target(upd_target), .hit(hit), .pred_target(pred_target), .next_pc(next_pc)
  );

  typedef struct packed {
    logic        uv;
    logic        ub;
    logic [31:0] upc;
    logic [31:0] utg;
    logic [31:0] fpc;
    logic        tk;
    logic        ehit;
    logic [31:0] etgt;
    logic [31:0] enext;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  // outputs are sampled before the row's own update takes effect
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,32'h0,32'h0,            32'h00001000,1'b1,1'b0,32'h0,   32'h00001004,4'd1},  // R1
    '{1'b1,1'b1,32'h1000,32'h2000,      32'h00001000,1'b1,1'b0,32'h0,   32'h00001004,4'd8},  // R8
    '{1'b0,1'b0,32'h0,32'h0,            32'h00001000,1'b1,1'b1,32'h2000,32'h00002000,4'd6},  // R6
    '{1'b0,1'b0,32'h0,32'h0,            32'h00001000,1'b0,1'b1,32'h2000,32'h00001004,4'd7},  // R7
    '{1'b1,1'b0,32'h1100,32'h3000,      32'h00002000,1'b1,1'b0,32'h0,   32'h00002004,4'd5},  // R5
    '{1'b0,1'b0,32'h0,32'h0,            32'h00001100,1'b1,1'b0,32'h0,   32'h00001104,4'd4},  // R4
    '{1'b0,1'b0,32'h0,32'h0,            32'h00001000,1'b1,1'b1,32'h2000,32'h00002000,4'd4},  // R4
    '{1'b1,1'b1,32'h1100,32'h3003,      32'h00001100,1'b1,1'b0,32'h0,   32'h00001104,4'd8},  // R8
    '{1'b0,1'b0,32'h0,32'h0,            32'h00001100,1'b1,1'b1,32'h3000,32'h00003000,4'd10}, // R10
    '{1'b0,1'b0,32'h0,32'h0,            32'h00001000,1'b1,1'b0,32'h0,   32'h00001004,4'd9},  // R9
    '{1'b1,1'b1,32'h10FC,32'h40,        32'h000010FC,1'b0,1'b0,32'h0,   32'h00001100,4'd8},  // R8
    '{1'b0,1'b0,32'h0,32'h0,            32'h000010FC,1'b1,1'b1,32'h40,  32'h00000040,4'd2},  // R2
    '{1'b0,1'b0,32'h0,32'h0,            32'h000020FC,1'b1,1'b0,32'h0,   32'h00002100,4'd2},  // R2
    '{1'b0,1'b0,32'h0,32'h0,            32'h000010F8,1'b1,1'b0,32'h0,   32'h000010FC,4'd2},  // R2
    '{1'b1,1'b1,32'h10F8,32'h500,       32'h00001100,1'b1,1'b1,32'h3000,32'h00003000,4'd3},  // R3
    '{1'b0,1'b0,32'h0,32'h0,            32'h000010F8,1'b1,1'b1,32'h500, 32'h00000500,4'd3},  // R3
    '{1'b0,1'b0,32'h0,32'h0,            32'hFFFFFFFC,1'b1,1'b0,32'h0,   32'h00000000,4'd11}, // R11
    '{1'b1,1'b1,32'hFFFFFFFC,32'h80,    32'h000010FC,1'b1,1'b1,32'h40,  32'h00000040,4'd8},  // R8
    '{1'b0,1'b0,32'h0,32'h0,            32'hFFFFFFFC,1'b0,1'b1,32'h80,  32'h00000000,4'd11}  // R11
  };

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic drive(input logic uv, input logic ub, input logic [31:0] upc,
                       input logic [31:0] utg, input logic [31:0] fpc, input logic tk);
    upd_valid = uv; upd_is_branch = ub; upd_pc = upc; upd_target = utg;
    fetch_pc = fpc; pred_taken = tk;
  endtask

  task automatic look(input string req, input logic ehit, input logic [31:0] etgt,
                      input logic [31:0] enext);
    #1;
    check({req, " hit"},    {31'b0, hit}, {31'b0, ehit});
    check({req, " target"}, pred_target, etgt);
    check({req, " next"},   next_pc, enext);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(1'b0, 1'b0, 32'h0, 32'h0, 32'h1000, 1'b1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    look("R1 in reset", 1'b0, 32'h0, 32'h1004);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].uv, VEC[i].ub, VEC[i].upc, VEC[i].utg, VEC[i].fpc, VEC[i].tk);
      look($sformatf("R%0d row%0d", VEC[i].req, i), VEC[i].ehit, VEC[i].etgt, VEC[i].enext);
      @(negedge clk);
    end

    // R1: reset in mid-run clears resident entries
    drive(1'b0, 1'b0, 32'h0, 32'h0, 32'h1100, 1'b1);
    look("R1 before reset", 1'b1, 32'h3000, 32'h3000);
    rst_n = 1'b0;
    look("R1 reset held", 1'b0, 32'h0, 32'h1104);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    look("R1 after reset", 1'b0, 32'h0, 32'h1104);
    drive(1'b0, 1'b0, 32'h0, 32'h0, 32'h10FC, 1'b1);
    look("R1 other entry", 1'b0, 32'h0, 32'h1100);

    // R3: table refills after reset
    drive(1'b1, 1'b1, 32'h1100, 32'h7774, 32'h1100, 1'b1);
    @(negedge clk);
    drive(1'b0, 1'b0, 32'h0, 32'h0, 32'h1100, 1'b1);
    look("R3 refill", 1'b1, 32'h7774, 32'h7774);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule